// File: doc/BRIEF.md
# Decimation Result Read Interface

This block sits between a sigma-delta decimation filter and a CPU bus. It keeps the most recent filter result, which can be up to 30 bits wide, and shows software a 16-bit slice of it through one result register. The result is latched only when the filter raises its valid strobe. The slice read depends on three things: the oversampling-ratio code, a polarity mode bit and a low-bits access bit.

With low-bits access off, the slice tracks the top of the filter word. The filter word is 3·log2(OSR) bits wide, so the slice moves as the OSR changes. With low-bits access on, the slice is the bottom 16 bits. A byte-size read always returns the bottom 8 bits.

An auto-toggle bit makes every read of the result register invert the low-bits access bit. Software can therefore collect the whole result with two back-to-back reads. Read data is registered and appears on `rd_data` on the clock after the read strobe. It holds there until the next read.

Top module: `sd_result_window`

## Requirements
- R1: After reset, `lsb_acc` is 0, the auto-toggle bit is 0, the latched result is 0 and `rd_data` is 0.
- R2: The latched result takes `res_data` only on a clock where `res_valid` is 1. Otherwise it keeps its value, so reads return the old result.
- R3: `osr_code` c (0..5) stands for OSR = 32·2^c and a filter width W = 15 + 3c. On a word read with `lsb_acc` = 0 and `unipolar` = 0, `rd_data` returns result bits W-1 down to W-16 on the clock after `rd_en`.
- R4: On a word read with `lsb_acc` = 0 and `unipolar` = 1, `rd_data` returns result bits W-2 down to W-17. For example, code 5 gives bits 28..13.
- R5: At `osr_code` 0, slice positions below result bit 0 read as zero. That is bit 0 in bipolar mode, and bits 1..0 in unipolar mode.
- R6: A word read with `lsb_acc` = 1 returns result bits 15..0, whatever the OSR code and polarity.
- R7: A read with `rd_byte` = 1 returns {8'h00, result[7:0]}, whatever the access bit, OSR code and polarity.
- R8: With the auto-toggle bit set, each read (word or byte) without a same-cycle control write inverts `lsb_acc` on the next clock.
- R9: A control write (`ctl_we`) loads `lsb_acc` from `ctl_lsb_acc` and the auto-toggle bit from `ctl_auto_tog`. Setting the auto-toggle bit does not by itself flip `lsb_acc`. A write in the same cycle as a read takes priority over the toggle, and the read data uses the access bit as it was before the write.
- R10: `osr_code` values 6 and 7 select the same slice as code 5.
- R11: With the auto-toggle bit clear, reads leave `lsb_acc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Filter result strobe |
| res_data | input | 30 | Filter result word |
| osr_code | input | 3 | Oversampling ratio code, OSR = 32·2^code |
| unipolar | input | 1 | 1 = unipolar slice, 0 = bipolar slice |
| ctl_we | input | 1 | Control write strobe |
| ctl_lsb_acc | input | 1 | Low-bits access value to write |
| ctl_auto_tog | input | 1 | Auto-toggle value to write |
| rd_en | input | 1 | Result register read strobe |
| rd_byte | input | 1 | 1 = byte-size read, 0 = word read |
| rd_data | output | 16 | Registered read data |
| lsb_acc | output | 1 | Current low-bits access bit |

## Verification
Two irregular result words are read at every OSR code in both polarities. Because the words are irregular, a slice that is off by one bit, or a mix-up between the two polarities, gives a different value. An all-ones word at the smallest OSR shows the zero-filled low positions, and codes 6 and 7 are compared against code 5.

Pairs of auto-toggle reads check that the two halves come back in order and that `lsb_acc` follows each read. A control write issued together with a read checks the priority between the two. A changed `res_data` presented without its strobe must leave the read values as they were.

// File: rtl/sdrw_pkg.sv
package sdrw_pkg;
   localparam int unsigned LOG2_OSR_MIN = 5;
   localparam int unsigned BITS_PER_OCT = 3;

   function automatic int unsigned res_width(input int unsigned code);
      return BITS_PER_OCT * (LOG2_OSR_MIN + code);
   endfunction
endpackage

// File: rtl/sdrw_capture.sv
module sdrw_capture #(
   parameter int unsigned RES_W = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic [RES_W-1:0] din,
   output logic [RES_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (vld) q <= din;
   end

   a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |=> $stable(q));
   a_r2_load_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> q == $past(din));
endmodule

// File: rtl/sdrw_ctl.sv
module sdrw_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic w_acc,
   input  logic w_tog,
   input  logic rd_en,
   output logic acc
);
   logic tog;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= 1'b0;
         tog <= 1'b0;
      end else if (we) begin
         acc <= w_acc;
         tog <= w_tog;
      end else if (rd_en && tog) begin
         acc <= ~acc;
      end
   end

   a_r8_flip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !we && tog) |=> acc != $past(acc));
   a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && !(rd_en && tog)) |=> $stable(acc));
   a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> acc == $past(w_acc));
endmodule

// File: rtl/sdrw_window.sv
module sdrw_window
   import sdrw_pkg::*;
#(
   parameter int unsigned RES_W   = 30,
   parameter int unsigned BUS_W   = 16,
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned N_CODES = 6,
   localparam int unsigned CODE_W = $clog2(N_CODES + 1),
   localparam int unsigned PAD    = 2,
   localparam int unsigned EXT_W  = RES_W + PAD
) (
   input  logic [RES_W-1:0]  res,
   input  logic [CODE_W-1:0] code,
   input  logic              uni,
   input  logic              acc,
   input  logic              byte_rd,
   output logic [BUS_W-1:0]  sel
);
   if (res_width(N_CODES - 1) != RES_W) begin : g_bad_width
      $error("RES_W must equal the widest filter output");
   end
   if (res_width(0) + PAD < BUS_W + 1) begin : g_bad_min
      $error("smallest filter output too narrow for the slice");
   end
   if (BYTE_W > BUS_W) begin : g_bad_byte
      $error("byte wider than bus");
   end

   logic [EXT_W-1:0] ext;
   logic [BUS_W-1:0] bip_win [N_CODES];
   logic [BUS_W-1:0] uni_win [N_CODES];

   assign ext = {res, {PAD{1'b0}}};

   for (genvar c = 0; c < N_CODES; c++) begin : g_code
      localparam int unsigned W    = res_width(c);
      localparam int unsigned LO_B = W + PAD - BUS_W;
      localparam int unsigned LO_U = LO_B - 1;
      assign bip_win[c] = ext[LO_B +: BUS_W];
      assign uni_win[c] = ext[LO_U +: BUS_W];
   end

   logic [CODE_W-1:0] code_eff;
   always_comb begin
      code_eff = (code > CODE_W'(N_CODES - 1)) ? CODE_W'(N_CODES - 1) : code;
      if (byte_rd)  sel = {{(BUS_W-BYTE_W){1'b0}}, res[BYTE_W-1:0]};
      else if (acc) sel = res[BUS_W-1:0];
      else if (uni) sel = uni_win[code_eff];
      else          sel = bip_win[code_eff];
   end
endmodule

// File: rtl/sd_result_window.sv
module sd_result_window #(
   parameter int unsigned RES_W   = 30,
   parameter int unsigned BUS_W   = 16,
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned N_CODES = 6,
   localparam int unsigned CODE_W = $clog2(N_CODES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [RES_W-1:0]  res_data,
   input  logic [CODE_W-1:0] osr_code,
   input  logic              unipolar,
   input  logic              ctl_we,
   input  logic              ctl_lsb_acc,
   input  logic              ctl_auto_tog,
   input  logic              rd_en,
   input  logic              rd_byte,
   output logic [BUS_W-1:0]  rd_data,
   output logic              lsb_acc
);
   logic [RES_W-1:0] cap;
   logic [BUS_W-1:0] sel;

   sdrw_capture #(.RES_W(RES_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .vld(res_valid), .din(res_data), .q(cap));

   sdrw_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .we(ctl_we), .w_acc(ctl_lsb_acc),
      .w_tog(ctl_auto_tog), .rd_en(rd_en), .acc(lsb_acc));

   sdrw_window #(.RES_W(RES_W), .BUS_W(BUS_W), .BYTE_W(BYTE_W), .N_CODES(N_CODES)) u_win (
      .res(cap), .code(osr_code), .uni(unipolar), .acc(lsb_acc),
      .byte_rd(rd_byte), .sel(sel));

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= sel;
   end

   a_r7_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_byte) |=> rd_data[BUS_W-1:BYTE_W] == '0);
   a_r6_low_word: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_byte && lsb_acc) |=> rd_data == $past(cap[BUS_W-1:0]));
   a_r1_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tb_sd_result_window.sv
`timescale 1ns/1ps
module tb_sd_result_window;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [29:0] res_data = '0;
   logic [2:0]  osr_code = '0;
   logic        unipolar = 1'b0;
   logic        ctl_we = 1'b0, ctl_lsb_acc = 1'b0, ctl_auto_tog = 1'b0;
   logic        rd_en = 1'b0, rd_byte = 1'b0;
   logic [15:0] rd_data;
   logic        lsb_acc;

   int n_chk = 0, n_fail = 0;
   logic [15:0] exp_q[$];
   string       req_q[$];
   logic [29:0] m_res = '0;
   bit          m_acc = 0, m_tog = 0;
   event        mon_ev;

   always #4 clk = ~clk;

   sd_result_window dut (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
      .osr_code(osr_code), .unipolar(unipolar), .ctl_we(ctl_we),
      .ctl_lsb_acc(ctl_lsb_acc), .ctl_auto_tog(ctl_auto_tog),
      .rd_en(rd_en), .rd_byte(rd_byte), .rd_data(rd_data), .lsb_acc(lsb_acc));

   function automatic logic [15:0] model(logic [29:0] r, int code, bit uni, bit acc, bit byt);
      logic [15:0] v = '0;
      int c = (code > 5) ? 5 : code;
      int w = 15 + 3 * c;
      int top = uni ? w - 2 : w - 1;
      if (byt) return {8'h00, r[7:0]};
      if (acc) return r[15:0];
      for (int i = 0; i < 16; i++) begin
         int src = top - 15 + i;
         if (src >= 0) v[i] = r[src];
      end
      return v;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(mon_ev) begin
      if (exp_q.size() > 0) check(req_q.pop_front(), {16'h0, rd_data}, {16'h0, exp_q.pop_front()});
   end

   task automatic load(logic [29:0] v);
      @(negedge clk);
      res_data = v; res_valid = 1'b1;
      @(negedge clk);
      res_valid = 1'b0;
      m_res = v;
   endtask

   task automatic wr_ctl(bit a, bit t);
      @(negedge clk);
      ctl_we = 1'b1; ctl_lsb_acc = a; ctl_auto_tog = t;
      @(negedge clk);
      ctl_we = 1'b0;
      m_acc = a; m_tog = t;
   endtask

   task automatic do_read(int code, bit uni, bit byt, bit wr, bit wa, bit wt, string req);
      @(negedge clk);
      osr_code = 3'(code); unipolar = uni; rd_byte = byt; rd_en = 1'b1;
      ctl_we = wr; ctl_lsb_acc = wa; ctl_auto_tog = wt;
      exp_q.push_back(model(m_res, code, uni, m_acc, byt));
      req_q.push_back(req);
      if (wr) begin m_acc = wa; m_tog = wt; end
      else if (m_tog) m_acc = ~m_acc;
      @(negedge clk);
      rd_en = 1'b0; ctl_we = 1'b0;
      -> mon_ev;
      #1;
      check({req, " lsb_acc"}, {31'h0, lsb_acc}, {31'h0, m_acc});
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rd_data", {16'h0, rd_data}, 32'h0);
      check("R1 lsb_acc", {31'h0, lsb_acc}, 32'h0);
      rst_n = 1'b1;
      do_read(5, 0, 0, 0, 0, 0, "R1 result zero");
      // R3 R4: every OSR code, both polarities, two patterns
      load(30'h3A5C_F0E1);
      for (int c = 0; c < 6; c++) begin
         do_read(c, 0, 0, 0, 0, 0, "R3 bipolar");
         do_read(c, 1, 0, 0, 0, 0, "R4 unipolar");
      end
      load(30'h15A3_3C96);
      for (int c = 0; c < 6; c++) begin
         do_read(c, 0, 0, 0, 0, 0, "R3 bipolar");
         do_read(c, 1, 0, 0, 0, 0, "R4 unipolar");
      end
      // R10 out-of-range codes
      do_read(6, 0, 0, 0, 0, 0, "R10 code6");
      do_read(7, 1, 0, 0, 0, 0, "R10 code7");
      // R5 zero fill at smallest OSR
      load(30'h3FFF_FFFF);
      do_read(0, 0, 0, 0, 0, 0, "R5 bipolar zero fill");
      do_read(0, 1, 0, 0, 0, 0, "R5 unipolar zero fill");
      // R2 no capture without strobe
      load(30'h2468_ACE1);
      @(negedge clk); res_data = 30'h1111_2222;
      do_read(5, 0, 0, 0, 0, 0, "R2 hold without strobe");
      // R6 R11 low-bits access, no toggle
      wr_ctl(1, 0);
      do_read(3, 1, 0, 0, 0, 0, "R6 low word");
      do_read(0, 0, 0, 0, 0, 0, "R11 no toggle");
      // R7 byte reads in both access states
      do_read(4, 0, 1, 0, 0, 0, "R7 byte acc1");
      wr_ctl(0, 0);
      do_read(2, 1, 1, 0, 0, 0, "R7 byte acc0");
      // R9 setting auto-toggle leaves access bit
      wr_ctl(0, 1);
      check("R9 toggle write keeps acc", {31'h0, lsb_acc}, 32'h0);
      // R8 two-read sequence and byte toggle
      do_read(5, 1, 0, 0, 0, 0, "R8 first half");
      do_read(5, 1, 0, 0, 0, 0, "R8 second half");
      do_read(5, 0, 1, 0, 0, 0, "R8 byte toggles");
      do_read(1, 0, 0, 0, 0, 0, "R8 after byte");
      // R9 write with read same cycle: write wins
      do_read(5, 0, 0, 1, 1, 1, "R9 write beats toggle");
      do_read(5, 0, 0, 1, 1, 0, "R9 write same value");
      repeat (2) @(negedge clk);
      finish_up();
   end
endmodule